// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block drives the fractional offset input of a feedback divider in a spread-spectrum clock PLL. It counts reference clocks to mark out fixed modulation periods. Within each period it produces a signed offset that climbs linearly from its most negative value to its most positive value and then returns. The offset is centred on zero, so the synthesised clock spends equal time above and below its nominal frequency. The modulation rate is the reference frequency divided by the period length.

A two-bit range code selects the period length and tells the output stage whether to multiply by one or by two. A four-bit amplitude code selects one of nine peak depths. An enable input chooses between sweeping and holding the offset at zero. With the offset held at zero the loop acts as a plain multiplier. Every setting is captured only at the start of a period, so a ramp is never cut short or reshaped partway.

The controller has five states. ST_IDLE is the reset state. It leaves on the first clock (transition "start") into the state the inputs select. ST_RISE moves to ST_FALL at the half-period point ("apex"). ST_FALL, ST_FLAT (modulation off) and ST_FAULT (invalid range) each reload at the last count of their period ("wrap"). A reload enters ST_FAULT if the range code is 11, ST_FLAT if the enable input is low, and ST_RISE otherwise.

Top module: `ssm_profile_gen`

## Requirements
- R1: While reset is asserted, freq_offset, period_start, range_err and mult_2x are all 0. The first period_start pulse appears in the cycle that follows the first clock edge after reset is released.
- R2: period_start is high for exactly one cycle at the start of each period. A period is 1166 clocks for range codes 00, 01 and 11, and 2332 clocks for range code 10.
- R3: While sweeping, let p be the cycle index within the period (0 at period_start), N the period length and H = N/2. The triangle value is t = 2p − H for p < H and t = 3H − 2p otherwise. freq_offset equals t·1166/N·(k+1), where k is the captured amplitude.
- R4: The sweep is centred and linear. With range 00 and amplitude 3, the offset over one period reaches +2332 at most and −2332 at least. It never changes by more than 2·(k+1) between adjacent cycles within a period.
- R5: Amplitude codes 0 to 8 give nine peak depths of ±583·(k+1). Codes 9 to 15 behave exactly like code 8 (peak ±5247).
- R6: If mod_en is 0 when a period starts, freq_offset stays 0 for that whole period. Period timing continues as in R2.
- R7: If range code 11 is captured at a period start, range_err is 1 and freq_offset is 0 for that 1166-clock period. Any other captured code gives range_err 0.
- R8: mult_2x is 1 exactly when the range code captured at the latest period start is 01. It is 0 in every other case, including while range_err is 1.
- R9: Changes to range_sel, mod_en or amp_code have no effect on any output until the next period_start. A change that is present at the clock edge ending the last cycle of a period applies to the period that edge starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; every period is counted in these cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| range_sel | input | 2 | Range code: 00 short 1X, 01 short 2X, 10 long 1X, 11 invalid |
| mod_en | input | 1 | 1 sweeps the offset, 0 holds it at zero |
| amp_code | input | 4 | Spread depth 0 to 8; larger values saturate to 8 |
| freq_offset | output | 16 | Signed two's-complement divider offset |
| period_start | output | 1 | One-cycle pulse on the first cycle of each period |
| range_err | output | 1 | High through a period captured with the invalid range code |
| mult_2x | output | 1 | High when the captured range asks for 2X output multiplication |

## Verification
The wrap transition is where the end of one period and the capture of new settings fall into the same cycle. In that cycle the final falling sample, the strobe and a possible change of state, period length and depth all meet. The bench provokes this by changing the inputs in the last cycle of an invalid-range period. It then checks that the very next cycle already shows the strobe, range_err low and the new depth. A second change is made in the middle of a period, and every cycle after it is judged against the old settings until the strobe.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RISE,
        ST_FALL,
        ST_FLAT,
        ST_FAULT
    } ssm_state_t;

    localparam logic [1:0] RNG_SHORT_1X = 2'b00;
    localparam logic [1:0] RNG_SHORT_2X = 2'b01;
    localparam logic [1:0] RNG_LONG_1X  = 2'b10;
    localparam logic [1:0] RNG_INVALID  = 2'b11;

    typedef struct packed {
        logic long_per;
        logic mul2x;
        logic bad;
    } rng_dec_t;

    function automatic rng_dec_t decode_range(input logic [1:0] code);
        rng_dec_t d;
        d = '0;
        unique case (code)
            RNG_SHORT_1X: d = '{long_per: 1'b0, mul2x: 1'b0, bad: 1'b0};
            RNG_SHORT_2X: d = '{long_per: 1'b0, mul2x: 1'b1, bad: 1'b0};
            RNG_LONG_1X:  d = '{long_per: 1'b1, mul2x: 1'b0, bad: 1'b0};
            RNG_INVALID:  d = '{long_per: 1'b0, mul2x: 1'b0, bad: 1'b1};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
    import ssm_pkg::*;
#(
    parameter int PERIOD_SHORT = 1166,
    parameter int AMP_W        = 4,
    parameter int AMP_MAX      = 8,
    parameter int CNT_W        = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       range_sel,
    input  logic             mod_en,
    input  logic [AMP_W-1:0] amp_code,
    output ssm_state_t       state_o,
    output logic [CNT_W-1:0] pos_o,
    output logic             long_o,
    output logic             mul2x_o,
    output logic [AMP_W-1:0] amp_o
);

    localparam int PERIOD_LONG = 2 * PERIOD_SHORT;
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(PERIOD_SHORT - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(PERIOD_LONG - 1);
    localparam logic [CNT_W-1:0] APEX_SHORT = CNT_W'(PERIOD_SHORT / 2 - 1);
    localparam logic [CNT_W-1:0] APEX_LONG  = CNT_W'(PERIOD_LONG / 2 - 1);
    localparam logic [AMP_W-1:0] AMP_SAT    = AMP_W'(AMP_MAX);

    ssm_state_t       state_q, state_n;
    logic [CNT_W-1:0] pos_q, pos_n;
    logic             long_q, long_n;
    logic             mul2x_q, mul2x_n;
    logic [AMP_W-1:0] amp_q, amp_n;

    logic [CNT_W-1:0] last_pos;
    logic [CNT_W-1:0] apex_pos;
    logic             at_wrap;
    logic             at_apex;
    logic             reload;
    rng_dec_t         dec;
    logic [AMP_W-1:0] amp_clamped;

    assign last_pos    = long_q ? LAST_LONG : LAST_SHORT;
    assign apex_pos    = long_q ? APEX_LONG : APEX_SHORT;
    assign at_wrap     = (pos_q == last_pos);
    assign at_apex     = (pos_q == apex_pos);
    assign dec         = decode_range(range_sel);
    assign amp_clamped = (amp_code > AMP_SAT) ? AMP_SAT : amp_code;

    // Next-state and counter logic
    always_comb begin
        state_n = state_q;
        pos_n   = pos_q + 1'b1;
        long_n  = long_q;
        mul2x_n = mul2x_q;
        amp_n   = amp_q;
        reload  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                reload = 1'b1;                   // start
            end
            ST_RISE: begin
                if (at_apex) begin
                    state_n = ST_FALL;           // apex
                end
            end
            ST_FALL, ST_FLAT, ST_FAULT: begin
                if (at_wrap) begin
                    reload = 1'b1;               // wrap
                end
            end
            default: begin
                reload = 1'b1;
            end
        endcase

        if (reload) begin
            pos_n   = '0;
            long_n  = dec.long_per;
            mul2x_n = dec.mul2x;
            amp_n   = amp_clamped;
            if (dec.bad) begin
                state_n = ST_FAULT;
            end else if (!mod_en) begin
                state_n = ST_FLAT;
            end else begin
                state_n = ST_RISE;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            long_q  <= 1'b0;
            mul2x_q <= 1'b0;
            amp_q   <= '0;
        end else begin
            state_q <= state_n;
            pos_q   <= pos_n;
            long_q  <= long_n;
            mul2x_q <= mul2x_n;
            amp_q   <= amp_n;
        end
    end

    assign state_o = state_q;
    assign pos_o   = pos_q;
    assign long_o  = long_q;
    assign mul2x_o = mul2x_q;
    assign amp_o   = amp_q;

endmodule

// File: rtl/ssm_shape.sv
module ssm_shape #(
    parameter int PERIOD_SHORT = 1166,
    parameter int CNT_W        = 12,
    parameter int SHP_W        = 11
) (
    input  logic                    falling,
    input  logic                    long_per,
    input  logic [CNT_W-1:0]        pos,
    output logic signed [SHP_W-1:0] shape_o
);

    localparam int HALF = PERIOD_SHORT / 2;
    localparam int WW   = CNT_W + 3;

    logic signed [WW-1:0] scaled_pos;
    logic signed [WW-1:0] rise_v;
    logic signed [WW-1:0] fall_v;

    // A long period advances at half speed, so both lengths share one amplitude
    always_comb begin
        if (long_per) begin
            scaled_pos = $signed({3'b000, pos});
        end else begin
            scaled_pos = $signed({2'b00, pos, 1'b0});
        end
        rise_v  = scaled_pos - WW'(HALF);
        fall_v  = WW'(3 * HALF) - scaled_pos;
        shape_o = falling ? SHP_W'(fall_v) : SHP_W'(rise_v);
    end

endmodule

// File: rtl/ssm_scale.sv
module ssm_scale #(
    parameter int SHP_W    = 11,
    parameter int AMP_W    = 4,
    parameter int OFS_W    = 16,
    parameter bit USE_MULT = 1'b0
) (
    input  logic signed [SHP_W-1:0] shape_i,
    input  logic [AMP_W-1:0]        amp_i,
    output logic signed [OFS_W-1:0] ofs_o
);

    localparam int MW = AMP_W + 1;

    logic [MW-1:0]           factor;
    logic signed [OFS_W-1:0] shape_ext;

    assign factor    = {1'b0, amp_i} + 1'b1;
    assign shape_ext = OFS_W'(shape_i);

    generate
        if (USE_MULT) begin : g_mult
            assign ofs_o = OFS_W'(shape_ext * $signed({1'b0, factor}));
        end else begin : g_shift_add
            logic signed [OFS_W-1:0] part [MW];
            for (genvar b = 0; b < MW; b++) begin : g_part
                assign part[b] = factor[b] ? (shape_ext <<< b) : '0;
            end
            always_comb begin
                ofs_o = '0;
                for (int i = 0; i < MW; i++) begin
                    ofs_o = ofs_o + part[i];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
    import ssm_pkg::*;
#(
    parameter int PERIOD_SHORT = 1166,
    parameter int AMP_W        = 4,
    parameter int AMP_MAX      = 8,
    parameter int OFS_W        = 16,
    parameter bit USE_MULT     = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              range_sel,
    input  logic                    mod_en,
    input  logic [AMP_W-1:0]        amp_code,
    output logic signed [OFS_W-1:0] freq_offset,
    output logic                    period_start,
    output logic                    range_err,
    output logic                    mult_2x
);

    localparam int CNT_W = $clog2(2 * PERIOD_SHORT);
    localparam int SHP_W = $clog2(PERIOD_SHORT / 2 + 1) + 1;

    ssm_state_t              state;
    logic [CNT_W-1:0]        pos;
    logic                    long_per;
    logic                    mul2x_q;
    logic [AMP_W-1:0]        amp_q;
    logic signed [SHP_W-1:0] shape;
    logic signed [OFS_W-1:0] scaled;

    ssm_ctrl #(
        .PERIOD_SHORT(PERIOD_SHORT),
        .AMP_W       (AMP_W),
        .AMP_MAX     (AMP_MAX),
        .CNT_W       (CNT_W)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .range_sel(range_sel),
        .mod_en   (mod_en),
        .amp_code (amp_code),
        .state_o  (state),
        .pos_o    (pos),
        .long_o   (long_per),
        .mul2x_o  (mul2x_q),
        .amp_o    (amp_q)
    );

    ssm_shape #(
        .PERIOD_SHORT(PERIOD_SHORT),
        .CNT_W       (CNT_W),
        .SHP_W       (SHP_W)
    ) shape_i (
        .falling (state == ST_FALL),
        .long_per(long_per),
        .pos     (pos),
        .shape_o (shape)
    );

    ssm_scale #(
        .SHP_W   (SHP_W),
        .AMP_W   (AMP_W),
        .OFS_W   (OFS_W),
        .USE_MULT(USE_MULT)
    ) scale_i (
        .shape_i(shape),
        .amp_i  (amp_q),
        .ofs_o  (scaled)
    );

    // Output process
    always_comb begin
        freq_offset  = '0;
        period_start = 1'b0;
        range_err    = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_RISE, ST_FALL: begin
                freq_offset  = scaled;
                period_start = (pos == '0);
            end
            ST_FLAT: begin
                period_start = (pos == '0);
            end
            ST_FAULT: begin
                period_start = (pos == '0);
                range_err    = 1'b1;
            end
            default: begin
            end
        endcase
        mult_2x = mul2x_q;
    end

endmodule

// File: rtl/ssm_profile_chk.sv
module ssm_profile_chk #(
    parameter int PERIOD_SHORT = 1166,
    parameter int AMP_MAX      = 8,
    parameter int OFS_W        = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [OFS_W-1:0] freq_offset,
    input logic                    period_start,
    input logic                    range_err,
    input logic                    mult_2x
);

    localparam int PEAK     = (PERIOD_SHORT / 2) * (AMP_MAX + 1);
    localparam int MAX_STEP = 2 * (AMP_MAX + 1);
    localparam int GAP_W    = $clog2(4 * PERIOD_SHORT);

    logic signed [OFS_W-1:0] prev_ofs;
    logic signed [OFS_W:0]   delta;
    logic signed [OFS_W:0]   mag;
    logic [GAP_W-1:0]        gap;
    logic                    seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ofs <= '0;
            gap      <= '0;
            seen     <= 1'b0;
        end else begin
            prev_ofs <= freq_offset;
            if (period_start) begin
                gap  <= GAP_W'(1);
                seen <= 1'b1;
            end else if (gap != {GAP_W{1'b1}}) begin
                gap <= gap + 1'b1;
            end
        end
    end

    always_comb begin
        delta = {freq_offset[OFS_W-1], freq_offset} - {prev_ofs[OFS_W-1], prev_ofs};
        mag   = (delta < 0) ? -delta : delta;
    end

    // R2
    strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && seen) |-> (gap == GAP_W'(PERIOD_SHORT) || gap == GAP_W'(2 * PERIOD_SHORT)));

    // R2
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);

    // R3
    start_at_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (freq_offset <= 0));

    // R4
    step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |-> (mag <= MAX_STEP));

    // R5
    peak_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_offset <= PEAK) && (freq_offset >= -PEAK));

    // R7
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        range_err |-> (freq_offset == 0 && !mult_2x));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> (period_start || $stable(range_err)));

    // R9
    mult_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_start |=> (period_start || $stable(mult_2x)));

endmodule

bind ssm_profile_gen ssm_profile_chk #(
    .PERIOD_SHORT(PERIOD_SHORT),
    .AMP_MAX     (AMP_MAX),
    .OFS_W       (OFS_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .freq_offset (freq_offset),
    .period_start(period_start),
    .range_err   (range_err),
    .mult_2x     (mult_2x)
);

// File: tb/ssm_profile_gen_tb_top.sv
`timescale 1ns/1ps
module ssm_profile_gen_tb_top;

    localparam int PS = 1166;

    typedef struct packed {
        logic signed [15:0] ofs;
        logic               stb;
        logic               err;
        logic               m2x;
        logic [3:0]         tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        range_sel = 2'b00;
    logic              mod_en = 1'b1;
    logic [3:0]        amp_code = 4'd3;
    logic signed [15:0] freq_offset;
    logic              period_start;
    logic              range_err;
    logic              mult_2x;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    ssm_profile_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .range_sel   (range_sel),
        .mod_en      (mod_en),
        .amp_code    (amp_code),
        .freq_offset (freq_offset),
        .period_start(period_start),
        .range_err   (range_err),
        .mult_2x     (mult_2x)
    );

    task automatic check(input string req, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
        end
    endtask

    // Reference model: predicts the outputs of the cycle following each edge
    int  m_pos, m_len, m_amp, m_mode;
    bit  m_started, m_2x;
    logic [1:0] m_rs;
    bit  m_en;

    function automatic int clamp_amp(input logic [3:0] a);
        return (a > 4'd8) ? 8 : int'(a);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 1'b0;
        end else begin
            exp_t e;
            int   half, t;
            if (!m_started || m_pos == m_len - 1) begin
                m_started = 1'b1;
                m_pos  = 0;
                m_rs   = range_sel;
                m_en   = mod_en;
                m_amp  = clamp_amp(amp_code);
                m_len  = (range_sel == 2'b10) ? 2 * PS : PS;
                m_2x   = (range_sel == 2'b01);
                m_mode = (range_sel == 2'b11) ? 2 : (!mod_en ? 1 : 0);
            end else begin
                m_pos++;
            end
            half = m_len / 2;
            t = (m_pos < half) ? (2 * m_pos - half) : (3 * half - 2 * m_pos);
            e.ofs = (m_mode == 0) ? 16'(t * PS / m_len * (m_amp + 1)) : 16'sd0;
            e.stb = (m_pos == 0);
            e.err = (m_mode == 2);
            e.m2x = m_2x;
            if (range_sel != m_rs || mod_en != m_en || clamp_amp(amp_code) != m_amp)
                e.tag = 4'd9;
            else if (m_mode == 1)
                e.tag = 4'd6;
            else if (m_mode == 2)
                e.tag = 4'd7;
            else
                e.tag = 4'd3;
            exp_q.push_back(e);
        end
    end

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd3: return "R3";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R9";
        endcase
    endfunction

    // Monitor: compare each cycle against the scoreboard
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(tag_name(e.tag), int'(freq_offset), int'(e.ofs), "offset");
            check((e.tag == 4'd9) ? "R9" : "R2", int'(period_start), int'(e.stb), "strobe");
            check((e.tag == 4'd9) ? "R9" : "R7", int'(range_err), int'(e.err), "range_err");
            check((e.tag == 4'd9) ? "R9" : "R8", int'(mult_2x), int'(e.m2x), "mult_2x");
        end
    end

    task automatic wait_strobe();
        do @(negedge clk); while (!period_start);
        #1;
    endtask

    // Starts in a strobe cycle, ends in the last cycle of that period
    task automatic measure(input int len, input int emax, input int emin, input string req);
        int mx, mn;
        mx = int'(freq_offset);
        mn = int'(freq_offset);
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            if (int'(freq_offset) > mx) mx = int'(freq_offset);
            if (int'(freq_offset) < mn) mn = int'(freq_offset);
        end
        #1;
        check(req, mx, emax, "period max");
        check(req, mn, emin, "period min");
    endtask

    task automatic measure_gap(input int expv, input string req);
        int n;
        wait_strobe();
        n = 0;
        do begin @(negedge clk); n++; end while (!period_start);
        #1;
        check(req, n, expv, "strobe spacing");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1", int'(freq_offset), 0, "offset in reset");
            check("R1", int'(period_start), 0, "strobe in reset");
            check("R1", int'(range_err), 0, "range_err in reset");
            check("R1", int'(mult_2x), 0, "mult_2x in reset");
        end
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1", int'(period_start), 1, "first strobe");

        // R4: range 00, amplitude 3, centred at +/-2332
        measure(PS, 2332, -2332, "R4");

        // R9: mid-period change to long range, depth 8
        repeat (400) @(negedge clk);
        #1;
        range_sel = 2'b10;
        amp_code  = 4'd8;
        wait_strobe();
        measure(2 * PS, 5247, -5247, "R5");

        // R5 / R8: saturating code on the 2X range
        range_sel = 2'b01;
        amp_code  = 4'd12;
        wait_strobe();
        check("R8", int'(mult_2x), 1, "mult_2x on range 01");
        measure(PS, 5247, -5247, "R5");

        // R6: modulation off
        range_sel = 2'b00;
        mod_en    = 1'b0;
        wait_strobe();
        check("R8", int'(mult_2x), 0, "mult_2x on range 00");
        measure(PS, 0, 0, "R6");

        // R7: invalid range
        range_sel = 2'b11;
        wait_strobe();
        check("R7", int'(range_err), 1, "range_err on code 11");
        measure(PS, 0, 0, "R7");

        // R9: change in the last cycle of a period applies at once
        range_sel = 2'b00;
        mod_en    = 1'b1;
        amp_code  = 4'd0;
        @(negedge clk);
        #1;
        check("R9", int'(period_start), 1, "strobe after last-cycle change");
        check("R9", int'(range_err), 0, "range_err cleared at wrap");
        measure(PS, 583, -583, "R5");

        // R2: spacing for short and long periods
        measure_gap(PS, "R2");
        range_sel = 2'b10;
        mod_en    = 1'b0;
        wait_strobe();
        measure_gap(2 * PS, "R2");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule